// File: doc/BRIEF.md
# SCL Half-Period Timer with Clock-Stretch Hold

This block sets the bit rate of a two-wire serial bus master. It produces a single-cycle `tick` that marks the end of each half of the SCL period. A reload value of `RELOAD_W` bits (7 by default) is loaded into a down counter. The counter steps only on an internal count enable that is high on every other system clock. When the count has run out, a tick is issued.

The automatic reload at zero is gated by the sampled level of the SCL wire. With SCL high, the counter reloads and keeps producing evenly spaced ticks. With SCL low, the counter waits at zero. This covers the case where another master or a slave holds the line low. The timed half-period then starts only when the wire is seen high again, so clock stretching and clock arbitration lengthen the period with no extra sequencing. A separate load strobe starts a half-period whatever the SCL level, for example at the start of a bus transaction. Dropping `enable` clears the counter and silences the output.

Top module: `scl_rate_gen`

## Requirements
- R1: A `load` pulse while enabled captures the `RELOAD_W`-bit `reload_val` R, whatever the level of `scl_in`. The first tick after it appears 2R+1 or 2R+2 clock edges after the edge that samples `load`. Which of the two applies depends on the phase of the half-rate count enable.
- R2: The counter steps down by one at most once every two system clocks and never wraps below zero.
- R3: With `scl_in` held high, consecutive ticks are exactly 2(R+1) clock cycles apart, for every R from 0 to 2^RELOAD_W-1.
- R4: `tick` is never high on two consecutive cycles.
- R5: When the count expires while `scl_in` is low, one tick is issued and no reload takes place. No further tick follows while `scl_in` stays low. A low `scl_in` does not slow the countdown that led to that expiry.
- R6: After a stretch, the next tick appears 2R+2 or 2R+3 clock edges after the first edge that samples `scl_in` high.
- R7: While `enable` is low, `tick` stays low and `load` and `scl_in` have no effect.
- R8: While `rst_n` is low, `tick` is low. The reset is applied at once and released in step with `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low clears the counter and blocks ticks |
| reload_val | input | RELOAD_W | Half-period reload value R |
| load | input | 1 | Strobe that starts a half-period unconditionally |
| scl_in | input | 1 | Sampled level of the SCL wire |
| tick | output | 1 | One-cycle pulse at the end of each half-period |

## Verification
Every result in this block is a tick that lands a known number of edges after its cause. The bench counts falling clock edges from the falling edge on which it applies a stimulus, and compares that count with the value due.

- **Steady running (R3):** the distance between two ticks is exact, 2R+2.
- **After a load (R1):** the first tick is due 2R+2 or 2R+3 falling edges later. The two values arise because the half-rate enable may or may not be high on the capturing edge.
- **After a stretch ends (R6):** the first tick is due 2R+3 or 2R+4 falling edges after the release, for the same reason.

The windows with no expected tick are counted over fixed spans, all sampled on the falling edge:
- the stretch itself (R5),
- the time disabled (R7),
- the cycle after every tick (R4).

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  // Action applied to the half-period counter in a given cycle.
  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_CLEAR  = 3'd1,
    ACT_LOAD   = 3'd2,
    ACT_RELOAD = 3'd3,
    ACT_DEC    = 3'd4
  } cnt_act_e;

endpackage

// File: rtl/scl_rate_phase.sv
module scl_rate_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic ce
);

  logic ph_q, ph_d;

  always_comb begin
    ph_d = 1'b0;
    if (enable) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign ce = ph_q;

  // R2
  ce_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (ce == !$past(ce)));

  // R7
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ce);

endmodule

// File: rtl/scl_rate_ctrl.sv
module scl_rate_ctrl
  import scl_rate_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     load,
  input  logic     ce,
  input  logic     cnt_zero,
  input  logic     scl_in,
  output cnt_act_e act,
  output logic     tick
);

  // spent: the current zero count has already produced its tick
  logic spent_q, spent_d;
  logic tick_q, tick_d;

  always_comb begin
    act     = ACT_HOLD;
    spent_d = spent_q;
    tick_d  = 1'b0;
    if (!enable) begin
      act     = ACT_CLEAR;
      spent_d = 1'b1;
    end else if (load) begin
      act     = ACT_LOAD;
      spent_d = 1'b0;
    end else if (ce) begin
      if (cnt_zero) begin
        tick_d = !spent_q;
        if (scl_in) begin
          act     = ACT_RELOAD;
          spent_d = 1'b0;
        end else begin
          act     = ACT_HOLD;
          spent_d = 1'b1;
        end
      end else begin
        act = ACT_DEC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spent_q <= 1'b1;
      tick_q  <= 1'b0;
    end else begin
      spent_q <= spent_d;
      tick_q  <= tick_d;
    end
  end

  assign tick = tick_q;

  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R7
  tick_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick);

  // R5
  tick_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load && ce && cnt_zero && !scl_in) |=> cnt_zero);

endmodule

// File: rtl/scl_rate_counter.sv
module scl_rate_counter
  import scl_rate_pkg::*;
#(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cnt_act_e            act,
  input  logic [RELOAD_W-1:0] reload_val,
  output logic                cnt_zero
);

  localparam logic [RELOAD_W-1:0] CNT_ZERO = '0;
  localparam logic [RELOAD_W-1:0] CNT_ONE  = {{(RELOAD_W-1){1'b0}}, 1'b1};

  logic [RELOAD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (act)
      ACT_CLEAR:            cnt_d = CNT_ZERO;
      ACT_LOAD, ACT_RELOAD: cnt_d = reload_val;
      ACT_DEC:              cnt_d = cnt_q - CNT_ONE;
      default:              cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_ZERO;
    else        cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == CNT_ZERO);

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DEC) |-> !cnt_zero);

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DEC) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R1
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD) |=> (cnt_q == $past(reload_val)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CLEAR) |=> cnt_zero);

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int RELOAD_W   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [RELOAD_W-1:0] reload_val,
  input  logic                load,
  input  logic                scl_in,
  output logic                tick
);

  localparam int SYNC_LAST = SYNC_STAGES - 1;

  // Reset: asserted asynchronously, released through a flop chain.
  logic [SYNC_LAST:0] rst_sync_q;
  logic               rst_core_n;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q[s] <= 1'b0;
        else if (s == 0) rst_sync_q[s] <= 1'b1;
        else rst_sync_q[s] <= rst_sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign rst_core_n = rst_sync_q[SYNC_LAST];

  logic     ce;
  logic     cnt_zero;
  cnt_act_e act;

  scl_rate_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .enable (enable),
    .ce     (ce)
  );

  scl_rate_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .enable   (enable),
    .load     (load),
    .ce       (ce),
    .cnt_zero (cnt_zero),
    .scl_in   (scl_in),
    .act      (act),
    .tick     (tick)
  );

  scl_rate_counter #(
    .RELOAD_W (RELOAD_W)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .act        (act),
    .reload_val (reload_val),
    .cnt_zero   (cnt_zero)
  );

  // R8
  reset_quiet_chk: assert property (@(posedge clk) !rst_core_n |-> !tick);

endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;

  localparam int RW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic [RW-1:0] reload_val;
  logic          load;
  logic          scl_in;
  logic          tick;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  scl_rate_gen #(.RELOAD_W(RW)) i_scl_rate_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .reload_val (reload_val),
    .load       (load),
    .scl_in     (scl_in),
    .tick       (tick)
  );

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  // Counts falling edges until tick is seen; d starts at d0. -1 on timeout.
  task automatic wait_tick(input int d0, input int limit, output int d);
    d = d0;
    while (d < limit) begin
      @(negedge clk);
      d++;
      load = 1'b0;
      if (tick) return;
    end
    d = -1;
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  // Tick must be low one cycle after a seen tick (R4)
  task automatic check_width();
    @(negedge clk);
    check(tick == 1'b0, "R4", tick, 0);
  endtask

  initial begin
    int d, c, r;
    rst_n = 1'b0; enable = 1'b0; reload_val = '0; load = 1'b0; scl_in = 1'b1;
    repeat (4) @(negedge clk);
    check(tick == 1'b0, "R8", tick, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: disabled, strobes and SCL toggling ignored
    c = 0;
    reload_val = 7'd2;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      scl_in = i[1];
      load   = i[2];
      if (tick) c++;
    end
    load = 1'b0; scl_in = 1'b1;
    check(c == 0, "R7", c, 0);

    // R1/R3: sweep every reload value with SCL high
    enable = 1'b1;
    @(negedge clk);
    for (int rv = 0; rv < (1 << RW); rv++) begin
      reload_val = rv[RW-1:0];
      load = 1'b1;
      wait_tick(0, 4 * rv + 20, d);
      check(d == 2*rv+2 || d == 2*rv+3, "R1", d, 2*rv+2);
      for (int k = 0; k < 2; k++) begin
        wait_tick(0, 4 * rv + 20, d);
        check(d == 2*rv+2, "R3", d, 2*rv+2);
      end
      check_width();
    end

    // R5/R6: stretch with R=5
    r = 5;
    reload_val = 7'd5;
    load = 1'b1;
    wait_tick(0, 100, d);
    scl_in = 1'b0;
    wait_tick(0, 100, d);
    check(d == 2*r+2, "R5", d, 2*r+2);
    count_ticks(40, c);
    check(c == 0, "R5", c, 0);
    scl_in = 1'b1;
    wait_tick(0, 100, d);
    check(d == 2*r+3 || d == 2*r+4, "R6", d, 2*r+3);
    wait_tick(0, 100, d);
    check(d == 2*r+2, "R3", d, 2*r+2);

    // R1/R5: load strobe while SCL low after expiry
    scl_in = 1'b0;
    wait_tick(0, 100, d);
    count_ticks(10, c);
    r = 3;
    reload_val = 7'd3;
    load = 1'b1;
    wait_tick(0, 100, d);
    check(d == 2*r+2 || d == 2*r+3, "R1", d, 2*r+2);
    count_ticks(50, c);
    check(c == 0, "R5", c, 0);

    // R7: disable mid-count with SCL high
    scl_in = 1'b1;
    reload_val = 7'd1;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    enable = 1'b0;
    c = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      load = i[0];
      if (tick) c++;
    end
    load = 1'b0;
    check(c == 0, "R7", c, 0);

    // R8: reset in mid-run
    enable = 1'b1;
    reload_val = 7'd0;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    rst_n = 1'b0;
    count_ticks(8, c);
    check(c == 0, "R8", c, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule